// File: doc/BRIEF.md
# Per-Channel Chunk Permission Checker

This block sits in front of a storage device and decides, for every request, whether the issuing channel may touch the bytes it names. The device address space is cut into fixed 2 MB chunks. For each chunk the block holds a small rights field per channel: no access, read-only, or read-write. Privileged software edits these fields through a management port. It can grant read-only access, upgrade or grant read-write access, drop one channel's rights, or drop every channel's rights on a chunk at once.

A request carries a channel number, a byte address, a byte length and a read/write flag. No alignment is required. A request may therefore straddle two chunks, and both must permit the operation. Exactly two cycles after a request is accepted, the block presents the same request on its output with a verdict. The verdict is a grant, a fault for a missing entry, or a separate fault for a write to a chunk that is only readable. The separate write fault lets software notice the first write to a chunk it filled for reading.

The rights table sits in synchronous memories that cannot be reset in one cycle. After reset, the block therefore spends one cycle per chunk clearing the table. During that window every request faults and management commands are dropped.

Top module: `chan_perm_check`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is low.
- R2: For the 2^CHUNK_BITS cycles after reset (256 by default), every request receives status 01 (no entry) and every management command is discarded, so rights granted then are absent afterwards.
- R3: A request accepted on a clock edge appears on the output exactly two edges later with `out_valid` high and its channel, address, length and write flag unchanged. Status codes are 00 grant, 01 no entry, 10 write not permitted, and 11 never occurs.
- R4: The chunk of a byte address is address bit CHUNK_SHIFT (21) upward. Rights are kept per channel, so an entry for one channel grants nothing to another channel or to another chunk.
- R5: Management op 00 sets the channel's rights on the chunk to read-only. Reads are then granted, and writes get status 10. A read never gets status 10.
- R6: Management op 01 sets the channel's rights to read-write, and writes to the chunk are then granted.
- R7: Management op 10 removes only the named channel's rights on the chunk. Other channels keep theirs.
- R8: Management op 11 removes every channel's rights on the chunk, and later requests to it get status 01.
- R9: A request covers the bytes from its address to address+length-1, or only its address byte when length is 0. It is granted only if every chunk it touches allows the operation. A missing entry in any touched chunk gives 01, and that takes priority over 10.
- R10: A request whose last byte lies beyond the top of the 2^(CHUNK_SHIFT+CHUNK_BITS)-byte address space gets status 01.
- R11: When a management command and a request arrive in the same cycle, the request is judged on the table as it was before the command. A request one cycle later sees the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_chan | input | CH_W | Issuing channel |
| req_addr | input | ADDR_W | Starting byte address |
| req_len | input | LEN_W | Length in bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| mgt_valid | input | 1 | Management command present |
| mgt_op | input | 2 | 00 read-only, 01 read-write, 10 drop channel, 11 drop chunk |
| mgt_chan | input | CH_W | Channel the command applies to |
| mgt_chunk | input | CHUNK_BITS | Chunk the command applies to |
| out_valid | output | 1 | Verdict present |
| out_status | output | 2 | 00 grant, 01 no entry, 10 write not permitted |
| out_chan | output | CH_W | Channel of the judged request |
| out_addr | output | ADDR_W | Address of the judged request |
| out_len | output | LEN_W | Length of the judged request |
| out_write | output | 1 | Write flag of the judged request |

## Verification
The assertions assume that `req_chan` and `mgt_chan` stay below NUM_CH and that reset is held for at least one edge before traffic starts. Their latency and field properties are only armed two cycles after reset.

The stimulus uses four channels and the default table. It only drives inputs while reset is low, and it keeps lengths below the chunk size, so a request touches at most two chunks.

The post-reset clearing window is hit on purpose with both a request and a grant. Everything else runs after the window: directed sequences for each rights transition, then a random phase that mixes commands and boundary-crossing requests over a few adjacent chunks.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [1:0] {
    ST_GRANT     = 2'b00,
    ST_NO_ENTRY  = 2'b01,
    ST_WR_DENIED = 2'b10
  } cpc_status_e;

  typedef enum logic [1:0] {
    OP_GRANT_RO   = 2'b00,
    OP_GRANT_RW   = 2'b01,
    OP_DROP_CHAN  = 2'b10,
    OP_DROP_CHUNK = 2'b11
  } cpc_op_e;

  // rights field: bit 0 readable, bit 1 writable
  localparam logic [1:0] RIGHT_NONE = 2'b00;
  localparam logic [1:0] RIGHT_RD   = 2'b01;
  localparam logic [1:0] RIGHT_RW   = 2'b11;

endpackage

// File: rtl/cpc_span.sv
// Turns a byte range into the first and last chunk it touches (R9, R10).
module cpc_span #(
  parameter int ADDR_W      = 29,
  parameter int LEN_W       = 16,
  parameter int CHUNK_SHIFT = 21,
  parameter int CHUNK_BITS  = 8
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [LEN_W-1:0]      len,
  output logic [CHUNK_BITS-1:0] first_chunk,
  output logic [CHUNK_BITS-1:0] last_chunk,
  output logic                  beyond
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] ext_addr;
  logic [EXT_W-1:0] ext_len;
  logic [EXT_W-1:0] ext_dec;
  logic [EXT_W-1:0] last_byte;
  logic             unused_low;

  always_comb begin
    ext_addr  = {1'b0, addr};
    ext_len   = {{(EXT_W-LEN_W){1'b0}}, len};
    ext_dec   = {{(EXT_W-1){1'b0}}, |len};
    last_byte = ext_addr + ext_len - ext_dec;
  end

  assign first_chunk = addr[CHUNK_SHIFT +: CHUNK_BITS];
  assign last_chunk  = last_byte[CHUNK_SHIFT +: CHUNK_BITS];
  assign beyond      = last_byte[ADDR_W];
  assign unused_low  = ^{last_byte[CHUNK_SHIFT-1:0], addr[CHUNK_SHIFT-1:0]};

endmodule

// File: rtl/cpc_rights_ram.sv
// One copy of the rights table: one narrow memory per channel lane so a
// lane can be written alone; registered read, old data on a same-address write.
module cpc_rights_ram #(
  parameter int ADDR_BITS = 8,
  parameter int LANES     = 4,
  parameter int LANE_W    = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [ADDR_BITS-1:0]    wr_addr,
  input  logic [LANE_W-1:0]       wr_rights,
  input  logic [ADDR_BITS-1:0]    rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_BITS;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_lane[g]) store[wr_addr] <= wr_rights;
      lane_q <= store[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/cpc_verdict.sv
// Combines the rights seen in the two touched chunks into a status (R5, R9, R10, R2).
module cpc_verdict
  import cpc_pkg::*;
(
  input  logic        blocked,
  input  logic        beyond,
  input  logic        is_write,
  input  logic [1:0]  rights_first,
  input  logic [1:0]  rights_last,
  output cpc_status_e status
);
  logic readable;
  logic writable;

  always_comb begin
    readable = rights_first[0] & rights_last[0];
    writable = rights_first[1] & rights_last[1];
    if (blocked || beyond || !readable) status = ST_NO_ENTRY;
    else if (is_write && !writable)     status = ST_WR_DENIED;
    else                                status = ST_GRANT;
  end

endmodule

// File: rtl/chan_perm_check.sv
module chan_perm_check
  import cpc_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CHUNK_BITS  = 8,
  parameter int CHUNK_SHIFT = 21,
  parameter int LEN_W       = 16,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W     = CHUNK_SHIFT + CHUNK_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [CH_W-1:0]       req_chan,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  req_write,
  input  logic                  mgt_valid,
  input  logic [1:0]            mgt_op,
  input  logic [CH_W-1:0]       mgt_chan,
  input  logic [CHUNK_BITS-1:0] mgt_chunk,
  output logic                  out_valid,
  output logic [1:0]            out_status,
  output logic [CH_W-1:0]       out_chan,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [LEN_W-1:0]      out_len,
  output logic                  out_write
);
  localparam int LOOKUPS  = 2;
  localparam int LANE_W   = 2;
  localparam int LANE_BUS = NUM_CH * LANE_W;

  // ---------------- post-reset table clearing (R2) ----------------
  logic                  sweeping;
  logic [CHUNK_BITS-1:0] sweep_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping  <= 1'b1;
      sweep_idx <= '0;
    end else if (sweeping) begin
      sweep_idx <= sweep_idx + 1'b1;
      if (&sweep_idx) sweeping <= 1'b0;
    end
  end

  // ---------------- table write port (R5..R8) ----------------
  logic [NUM_CH-1:0]     chan_onehot;
  logic [NUM_CH-1:0]     wr_lane;
  logic [CHUNK_BITS-1:0] wr_addr;
  logic [LANE_W-1:0]     wr_rights;

  assign chan_onehot = NUM_CH'(1) << mgt_chan;

  always_comb begin
    wr_lane   = '0;
    wr_addr   = mgt_chunk;
    wr_rights = RIGHT_NONE;
    if (sweeping) begin
      wr_lane = '1;
      wr_addr = sweep_idx;
    end else if (mgt_valid) begin
      case (cpc_op_e'(mgt_op))
        OP_GRANT_RO:   begin wr_lane = chan_onehot; wr_rights = RIGHT_RD; end
        OP_GRANT_RW:   begin wr_lane = chan_onehot; wr_rights = RIGHT_RW; end
        OP_DROP_CHAN:  begin wr_lane = chan_onehot; wr_rights = RIGHT_NONE; end
        OP_DROP_CHUNK: begin wr_lane = '1;          wr_rights = RIGHT_NONE; end
        default:       wr_lane = '0;
      endcase
    end
  end

  // ---------------- lookup: two chunks per request (R9) ----------------
  logic [CHUNK_BITS-1:0] lk_chunk  [LOOKUPS];
  logic [LANE_BUS-1:0]   lk_rights [LOOKUPS];
  logic                  req_beyond;

  cpc_span #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .CHUNK_SHIFT(CHUNK_SHIFT), .CHUNK_BITS(CHUNK_BITS)
  ) u_span (
    .addr(req_addr), .len(req_len),
    .first_chunk(lk_chunk[0]), .last_chunk(lk_chunk[1]),
    .beyond(req_beyond)
  );

  for (genvar p = 0; p < LOOKUPS; p++) begin : g_copy
    cpc_rights_ram #(
      .ADDR_BITS(CHUNK_BITS), .LANES(NUM_CH), .LANE_W(LANE_W)
    ) u_ram (
      .clk(clk), .wr_lane(wr_lane), .wr_addr(wr_addr), .wr_rights(wr_rights),
      .rd_addr(lk_chunk[p]), .rd_data(lk_rights[p])
    );
  end

  // ---------------- stage 1: request beside table read ----------------
  logic              s1_valid;
  logic [CH_W-1:0]   s1_chan;
  logic [ADDR_W-1:0] s1_addr;
  logic [LEN_W-1:0]  s1_len;
  logic              s1_write;
  logic              s1_beyond;
  logic              s1_blocked;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    s1_chan    <= req_chan;
    s1_addr    <= req_addr;
    s1_len     <= req_len;
    s1_write   <= req_write;
    s1_beyond  <= req_beyond;
    s1_blocked <= sweeping;
  end

  logic [LANE_W-1:0] s1_rights_first;
  logic [LANE_W-1:0] s1_rights_last;
  cpc_status_e       s1_status;

  assign s1_rights_first = lk_rights[0][{s1_chan, 1'b0} +: LANE_W];
  assign s1_rights_last  = lk_rights[1][{s1_chan, 1'b0} +: LANE_W];

  cpc_verdict u_verdict (
    .blocked(s1_blocked), .beyond(s1_beyond), .is_write(s1_write),
    .rights_first(s1_rights_first), .rights_last(s1_rights_last),
    .status(s1_status)
  );

  // ---------------- stage 2: registered verdict (R3) ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_status <= ST_GRANT;
    end else begin
      out_valid  <= s1_valid;
      out_status <= s1_status;
    end
  end

  always_ff @(posedge clk) begin
    out_chan  <= s1_chan;
    out_addr  <= s1_addr;
    out_len   <= s1_len;
    out_write <= s1_write;
  end

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int NUM_CH      = 4,
  parameter int CHUNK_BITS  = 8,
  parameter int CHUNK_SHIFT = 21,
  parameter int LEN_W       = 16,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W     = CHUNK_SHIFT + CHUNK_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [CH_W-1:0]   req_chan,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_write,
  input logic              out_valid,
  input logic [1:0]        out_status,
  input logic [CH_W-1:0]   out_chan,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_write
);
  localparam int DEPTH = 1 << CHUNK_BITS;

  logic [CHUNK_BITS:0] age;
  logic [1:0]          warm;
  logic                early;
  logic [ADDR_W:0]     out_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      age  <= '0;
      warm <= '0;
    end else begin
      if (age != (CHUNK_BITS+1)'(DEPTH)) age <= age + 1'b1;
      if (warm != 2'd2) warm <= warm + 1'b1;
    end
  end

  assign early   = age < (CHUNK_BITS+1)'(DEPTH);
  assign out_end = {1'b0, out_addr} + {{(ADDR_W+1-LEN_W){1'b0}}, out_len}
                 - {{ADDR_W{1'b0}}, |out_len};

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !out_valid);

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_valid == $past(req_valid, 2)));

  a_r3_fields: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && out_valid) |->
      (out_chan == $past(req_chan, 2) && out_addr == $past(req_addr, 2) &&
       out_len == $past(req_len, 2) && out_write == $past(req_write, 2)));

  a_r3_code_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_status != 2'b11);

  a_r2_window_faults: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(req_valid && early, 2)) |-> out_status == 2'b01);

  a_r5_read_no_wdeny: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_write) |-> out_status != 2'b10);

  a_r10_beyond_faults: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_end[ADDR_W]) |-> out_status == 2'b01);

endmodule

bind chan_perm_check cpc_checker #(
  .NUM_CH(NUM_CH), .CHUNK_BITS(CHUNK_BITS),
  .CHUNK_SHIFT(CHUNK_SHIFT), .LEN_W(LEN_W)
) u_cpc_checker (.*);

// File: tb/chan_perm_check_bench.sv
`timescale 1ns/1ps
module chan_perm_check_bench;
  localparam int NCH = 4;
  localparam int CB  = 8;
  localparam int CS  = 21;
  localparam int LW  = 16;
  localparam int AW  = CS + CB;
  localparam int DEP = 1 << CB;
  localparam longint CHK = 64'd1 << CS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_chan = '0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_write = 1'b0;
  logic          mgt_valid = 1'b0;
  logic [1:0]    mgt_op = '0;
  logic [1:0]    mgt_chan = '0;
  logic [CB-1:0] mgt_chunk = '0;
  logic          out_valid;
  logic [1:0]    out_status;
  logic [1:0]    out_chan;
  logic [AW-1:0] out_addr;
  logic [LW-1:0] out_len;
  logic          out_write;

  chan_perm_check u_chan_perm_check (.*);

  typedef struct {
    bit     v;
    int     st;
    int     hint;
    string  tag;
    int     ch;
    longint addr;
    int     len;
    bit     wr;
  } exp_t;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    tr [DEP][NCH];
  bit    tw [DEP][NCH];
  int    since = 0;
  exp_t  e1, e2, nw;
  string cur_tag = "R3";
  int    cur_hint = -1;
  bit    chk_en = 1'b0;

  function automatic int model_status(int ch, longint a, longint l, bit w);
    longint last;
    bit miss;
    bit wdeny;
    last = (l == 0) ? a : a + l - 1;
    if (last >= (64'd1 << AW)) return 1;
    miss = 0;
    wdeny = 0;
    for (longint c = a >> CS; c <= (last >> CS); c++) begin
      if (!tr[c][ch]) miss = 1;
      else if (w && !tw[c][ch]) wdeny = 1;
    end
    if (miss) return 1;
    if (wdeny) return 2;
    return 0;
  endfunction

  // behavioural reference, two-cycle pipe of expectations
  always @(posedge clk) begin
    chk_en <= !rst;
    if (rst) begin
      for (int c = 0; c < DEP; c++)
        for (int h = 0; h < NCH; h++) begin tr[c][h] = 0; tw[c][h] = 0; end
      since = 0;
      e1.v = 0;
      e2.v = 0;
    end else begin
      e2 = e1;
      nw.v    = req_valid;
      nw.ch   = req_chan;
      nw.addr = req_addr;
      nw.len  = req_len;
      nw.wr   = req_write;
      nw.hint = cur_hint;
      nw.tag  = cur_tag;
      nw.st   = (since < DEP) ? 1 : model_status(req_chan, req_addr, req_len, req_write);
      e1 = nw;
      if (mgt_valid && since >= DEP) begin
        case (mgt_op)
          2'b00: begin tr[mgt_chunk][mgt_chan] = 1; tw[mgt_chunk][mgt_chan] = 0; end
          2'b01: begin tr[mgt_chunk][mgt_chan] = 1; tw[mgt_chunk][mgt_chan] = 1; end
          2'b10: begin tr[mgt_chunk][mgt_chan] = 0; tw[mgt_chunk][mgt_chan] = 0; end
          default:
            for (int h = 0; h < NCH; h++) begin tr[mgt_chunk][h] = 0; tw[mgt_chunk][h] = 0; end
        endcase
      end
      since++;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      n_chk++;
      if (out_valid !== e2.v ||
          (e2.v && (out_status !== 2'(e2.st) || out_chan !== 2'(e2.ch) ||
                    out_addr !== AW'(e2.addr) || out_len !== LW'(e2.len) ||
                    out_write !== e2.wr))) begin
        n_fail++;
        $display("FAIL %s model compare: valid=%0b status=%0d chan=%0d addr=%h len=%0d wr=%0b expected valid=%0b status=%0d chan=%0d addr=%h len=%0d wr=%0b",
                 e2.tag, out_valid, out_status, out_chan, out_addr, out_len, out_write,
                 e2.v, e2.st, e2.ch, e2.addr, e2.len, e2.wr);
      end
      if (e2.v && e2.hint >= 0) begin
        n_chk++;
        if (out_status !== 2'(e2.hint)) begin
          n_fail++;
          $display("FAIL %s directed status: got %0d expected %0d", e2.tag, out_status, e2.hint);
        end
      end
    end
  end

  task automatic go_req(int ch, longint a, int l, bit w, int hint, string tag);
    req_valid = 1'b1;
    req_chan  = 2'(ch);
    req_addr  = a[AW-1:0];
    req_len   = LW'(l);
    req_write = w;
    cur_hint  = hint;
    cur_tag   = tag;
    @(negedge clk);
    req_valid = 1'b0;
    cur_hint  = -1;
  endtask

  task automatic go_mgt(int op, int ch, int chunk);
    mgt_valid = 1'b1;
    mgt_op    = 2'(op);
    mgt_chan  = 2'(ch);
    mgt_chunk = CB'(chunk);
    @(negedge clk);
    mgt_valid = 1'b0;
  endtask

  task automatic go_both(int op, int mch, int chunk, int ch, longint a, int l, bit w,
                         int hint, string tag);
    mgt_valid = 1'b1;
    mgt_op    = 2'(op);
    mgt_chan  = 2'(mch);
    mgt_chunk = CB'(chunk);
    go_req(ch, a, l, w, hint, tag);
    mgt_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 out_valid in reset: got %0b expected 0", out_valid);
    end
    rst = 1'b0;
    idle(3);

    // R2: clearing window
    go_mgt(1, 0, 3);
    go_req(0, 3*CHK, 4, 0, 1, "R2");
    idle(DEP);
    go_req(0, 3*CHK, 4, 0, 1, "R2");

    // R4: per channel, per chunk
    go_mgt(0, 1, 5);
    go_req(1, 5*CHK + 100, 8, 0, 0, "R4");
    go_req(2, 5*CHK + 100, 8, 0, 1, "R4");
    go_req(1, 6*CHK + 100, 8, 0, 1, "R4");
    // R5: read-only chunk refuses writes
    go_req(1, 5*CHK, 1, 1, 2, "R5");
    // R6: upgrade
    go_mgt(1, 1, 5);
    go_req(1, 5*CHK + 7, 3, 1, 0, "R6");
    // R7: drop one channel
    go_mgt(0, 2, 5);
    go_mgt(2, 1, 5);
    go_req(1, 5*CHK, 4, 0, 1, "R7");
    go_req(2, 5*CHK, 4, 0, 0, "R7");
    // R8: drop whole chunk
    go_mgt(1, 3, 5);
    go_mgt(3, 0, 5);
    go_req(2, 5*CHK, 4, 0, 1, "R8");
    go_req(3, 5*CHK, 4, 1, 1, "R8");

    // R9: spanning
    go_mgt(1, 0, 10);
    go_mgt(0, 0, 11);
    go_req(0, 11*CHK - 8, 16, 1, 2, "R9");
    go_req(0, 11*CHK - 8, 16, 0, 0, "R9");
    go_req(0, 11*CHK - 1, 1, 1, 0, "R9");
    go_req(0, 11*CHK - 1, 0, 1, 0, "R9");
    go_req(0, 11*CHK - 1, 2, 1, 2, "R9");
    go_req(0, 12*CHK - 4, 8, 1, 1, "R9");

    // R10: top of address space
    go_mgt(1, 3, DEP - 1);
    go_req(3, DEP*CHK - 4, 4, 1, 0, "R10");
    go_req(3, DEP*CHK - 4, 5, 0, 1, "R10");
    go_req(3, DEP*CHK - 1, 0, 0, 0, "R10");

    // R11: same-cycle ordering
    go_both(0, 3, 20, 3, 20*CHK, 4, 0, 1, "R11");
    go_req(3, 20*CHK, 4, 0, 0, "R11");
    go_both(2, 3, 20, 3, 20*CHK, 4, 0, 0, "R11");
    go_req(3, 20*CHK, 4, 0, 1, "R11");

    // mixed random traffic around adjacent chunks
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 2);
      if (k == 0) begin
        go_mgt($urandom_range(0, 3), $urandom_range(0, 3), 40 + $urandom_range(0, 3));
      end else if (k == 1) begin
        longint a;
        a = (40 + $urandom_range(0, 3)) * CHK + $urandom_range(0, 63)
            - 32 + (($urandom_range(0, 1) == 1) ? CHK / 2 : 0);
        go_req($urandom_range(0, 3), a, $urandom_range(0, 96), 1'($urandom_range(0, 1)), -1, "R9");
      end else begin
        go_both($urandom_range(0, 3), $urandom_range(0, 3), 40 + $urandom_range(0, 3),
                $urandom_range(0, 3), (40 + $urandom_range(0, 3)) * CHK + $urandom_range(0, 15),
                $urandom_range(0, 8), 1'($urandom_range(0, 1)), -1, "R11");
      end
    end

    idle(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule